// File: doc/BRIEF.md
# Per-Priority Pause Threshold Generator

This block makes the receive-side pause decisions for a lossless link that carries eight traffic priorities. It keeps a byte-occupancy counter for each priority, fed by the enqueue and dequeue byte counts of the receive buffer. It compares the free space of each flow-control group against a skid allowance. The skid allowance is the data that still arrives after a pause decision, because a frame already in flight on each side of the link must finish first. When a group runs short of space, the block asks a frame transmitter to pause the priorities in that group. When the space has grown well beyond the skid allowance, it asks the transmitter to resume them.

Each request carries an 8-bit vector naming the priorities it addresses and one 16-bit pause time per priority. A nonzero time pauses the priority and zero resumes it. Events that arise together, or while the transmitter has not yet taken a request, are merged into one request. While a priority stays paused, the block reissues its pause before the far end's timer can run out. Priorities can be mapped onto shared groups so that they share one occupancy sum and one decision.

Top module: `ppt_pause_gen`

## Requirements
- R1: The occupancy of priority p rises by enqLen when enqValid is high with enqPri equal to p. It falls by deqLen when deqValid is high with deqPri equal to p, and both may happen in one cycle. With each priority in its own group, a priority's decisions depend only on its own occupancy.
- R2: The skid allowance is 2*cfgMaxFrame + cfgLinkDelay, and free space is cfgCapacity minus the group occupancy, or zero if the occupancy is larger. A running group whose free space is at or below the skid allowance becomes paused and issues one pause request. More bytes arriving while it is paused issue nothing further.
- R3: A paused group resumes, and issues one resume request, once its free space exceeds twice the skid allowance. Free space above one allowance but not above two issues nothing.
- R4: Bit p of reqEnable names priority p. Bits [16p+15:16p] of reqTimes hold cfgPauseTime if priority p is paused when the request is formed, and zero if it is resumed or not named. A valid request never has an empty reqEnable. After reset, reqValid and errFlag are low.
- R5: If counts are sampled at clock edge k and the request output is idle, the resulting request is valid after edge k+2.
- R6: Pause and resume events from the same cycle go out together in one request.
- R7: reqValid and the payload stay unchanged until an edge at which reqReady is high. reqValid is low in the cycle after that acceptance. Events that arise while a request waits are gathered and sent in the next request, which becomes valid one edge after the accepting edge.
- R8: Forming a request loads a refresh counter with cfgRefresh for each named priority. If a priority is still paused, a fresh pause request for it becomes valid cfgRefresh+2 cycles after the earlier request first became valid, provided reqReady stays high.
- R9: Bits [3p+2:3p] of cfgGroup give the group of priority p. The group's occupancy is the sum of its members' occupancies, and all members are named together in that group's requests.
- R10: An occupancy counter that would go below zero stays at zero, and one that would exceed its maximum stays at all ones. In either case errFlag is set and stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enqValid | input | 1 | Enqueue byte count valid |
| enqPri | input | 3 | Priority of the enqueued bytes |
| enqLen | input | 16 | Bytes enqueued |
| deqValid | input | 1 | Dequeue byte count valid |
| deqPri | input | 3 | Priority of the dequeued bytes |
| deqLen | input | 16 | Bytes dequeued |
| cfgCapacity | input | 16 | Buffer bytes available to each group |
| cfgMaxFrame | input | 16 | Largest frame length in bytes |
| cfgLinkDelay | input | 16 | Link round-trip term in bytes |
| cfgPauseTime | input | 16 | Pause time placed in pause requests |
| cfgRefresh | input | 16 | Cycles between reissued pause requests |
| cfgGroup | input | 24 | Group id of each priority, 3 bits per priority |
| reqValid | output | 1 | Request to the frame transmitter valid |
| reqReady | input | 1 | Transmitter accepts the request |
| reqEnable | output | 8 | Priorities addressed by the request |
| reqTimes | output | 128 | Pause time per priority, 16 bits each |
| errFlag | output | 1 | Sticky occupancy saturation flag |

## Verification
A request is due two cycles after the edge that samples the byte count that caused it. It is due one cycle after the accepting edge when it waited behind an earlier request, and cfgRefresh+2 cycles after the prior request appeared when it is a refresh. The driver records the cycle in which it drives each stimulus and queues the expected request with that due cycle. The monitor checks, on the falling clock edge, that each request first appears in exactly its due cycle and carries the expected vector and times when it is accepted. Any request that appears with nothing queued counts as a failure. errFlag is sampled one cycle after the faulting count.

// File: rtl/ppt_pkg.sv
package ppt_pkg;
  localparam int unsigned PRI_COUNT = 8;
  localparam int unsigned PRI_W = $clog2(PRI_COUNT);

  // strobes from control to datapath
  typedef struct packed {
    logic                 launch;
    logic [PRI_COUNT-1:0] launchMask;
  } ctlStrobe_t;

  // level information from datapath to control
  typedef struct packed {
    logic [PRI_COUNT-1:0] xoffLevel;   // per group: free <= skid
    logic [PRI_COUNT-1:0] xonLevel;    // per group: free > 2*skid
    logic [PRI_COUNT-1:0] refreshDue;  // per priority
  } dpStatus_t;

  function automatic logic [PRI_W-1:0] groupOf(input logic [PRI_COUNT*PRI_W-1:0] map,
                                               input int p);
    return map[p*PRI_W +: PRI_W];
  endfunction
endpackage

// File: rtl/ppt_occ_counter.sv
module ppt_occ_counter #(
  parameter int unsigned OCC_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [OCC_W-1:0] addAmt,
  input  logic [OCC_W-1:0] subAmt,
  output logic [OCC_W-1:0] occ,
  output logic             fault
);
  localparam int unsigned EXT_W = OCC_W + 2;

  logic [EXT_W-1:0] sum;
  logic underflow;
  logic overflow;

  always_comb begin
    sum       = {2'b00, occ} + {2'b00, addAmt} - {2'b00, subAmt};
    underflow = sum[EXT_W-1];
    overflow  = !sum[EXT_W-1] && sum[OCC_W];
    fault     = underflow || overflow;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          occ <= '0;
    else if (underflow) occ <= '0;
    else if (overflow)  occ <= '1;
    else                occ <= sum[OCC_W-1:0];
  end
endmodule

// File: rtl/ppt_datapath.sv
module ppt_datapath
  import ppt_pkg::*;
#(
  parameter int unsigned OCC_W  = 16,
  parameter int unsigned TIME_W = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        enqValid,
  input  logic [PRI_W-1:0]            enqPri,
  input  logic [OCC_W-1:0]            enqLen,
  input  logic                        deqValid,
  input  logic [PRI_W-1:0]            deqPri,
  input  logic [OCC_W-1:0]            deqLen,
  input  logic [OCC_W-1:0]            cfgCapacity,
  input  logic [OCC_W-1:0]            cfgMaxFrame,
  input  logic [OCC_W-1:0]            cfgLinkDelay,
  input  logic [TIME_W-1:0]           cfgPauseTime,
  input  logic [TIME_W-1:0]           cfgRefresh,
  input  logic [PRI_COUNT*PRI_W-1:0]  cfgGroup,
  input  logic [PRI_COUNT-1:0]        groupPaused,
  input  ctlStrobe_t                  strobe,
  output dpStatus_t                   status,
  output logic [PRI_COUNT*TIME_W-1:0] reqTimes,
  output logic                        errFlag
);
  localparam int unsigned SUM_W  = OCC_W + PRI_W;
  localparam int unsigned SKID_W = OCC_W + 2;
  localparam int unsigned CMP_W  = SKID_W + 1;

  logic [OCC_W-1:0]     occ [PRI_COUNT];
  logic [PRI_COUNT-1:0] fault;
  logic [PRI_COUNT-1:0] priPaused;
  logic [SUM_W-1:0]     groupOcc [PRI_COUNT];
  logic [SKID_W-1:0]    skid;

  // occupancy counters, one per priority
  for (genvar p = 0; p < PRI_COUNT; p++) begin : g_occ
    logic [OCC_W-1:0] addAmt;
    logic [OCC_W-1:0] subAmt;
    assign addAmt = (enqValid && enqPri == PRI_W'(p)) ? enqLen : '0;
    assign subAmt = (deqValid && deqPri == PRI_W'(p)) ? deqLen : '0;
    ppt_occ_counter #(.OCC_W(OCC_W)) u_cnt (
      .clk   (clk),
      .rstN  (rstN),
      .addAmt(addAmt),
      .subAmt(subAmt),
      .occ   (occ[p]),
      .fault (fault[p])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN)       errFlag <= 1'b0;
    else if (|fault) errFlag <= 1'b1;
  end

  // skid allowance: two largest frames plus the link term
  assign skid = {1'b0, cfgMaxFrame, 1'b0} + SKID_W'(cfgLinkDelay);

  // sum member occupancies into each group
  always_comb begin
    for (int g = 0; g < PRI_COUNT; g++) begin
      groupOcc[g] = '0;
      for (int p = 0; p < PRI_COUNT; p++) begin
        if (groupOf(cfgGroup, p) == PRI_W'(g)) groupOcc[g] = groupOcc[g] + SUM_W'(occ[p]);
      end
    end
  end

  // free-space compare per group
  for (genvar g = 0; g < PRI_COUNT; g++) begin : g_level
    logic [OCC_W-1:0] freeBytes;
    assign freeBytes = (groupOcc[g] >= SUM_W'(cfgCapacity)) ? '0
                     : OCC_W'(SUM_W'(cfgCapacity) - groupOcc[g]);
    assign status.xoffLevel[g] = CMP_W'(freeBytes) <= CMP_W'(skid);
    assign status.xonLevel[g]  = CMP_W'(freeBytes) >  {skid, 1'b0};
  end

  // refresh timers and request payload, per priority
  for (genvar p = 0; p < PRI_COUNT; p++) begin : g_pri
    logic [TIME_W-1:0] refreshCnt;
    logic              named;

    assign priPaused[p] = groupPaused[groupOf(cfgGroup, p)];
    assign named        = strobe.launch && strobe.launchMask[p];

    always_ff @(posedge clk) begin
      if (!rstN)                               refreshCnt <= '0;
      else if (named)                          refreshCnt <= cfgRefresh;
      else if (priPaused[p] && refreshCnt != '0) refreshCnt <= refreshCnt - 1'b1;
    end

    assign status.refreshDue[p] = priPaused[p] && (refreshCnt == '0);

    always_ff @(posedge clk) begin
      if (!rstN)             reqTimes[p*TIME_W +: TIME_W] <= '0;
      else if (strobe.launch) reqTimes[p*TIME_W +: TIME_W] <=
                               (strobe.launchMask[p] && priPaused[p]) ? cfgPauseTime : '0;
    end
  end
endmodule

// File: rtl/ppt_control.sv
module ppt_control
  import ppt_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  dpStatus_t                  status,
  input  logic [PRI_COUNT*PRI_W-1:0] cfgGroup,
  input  logic                       reqReady,
  output logic [PRI_COUNT-1:0]       groupPaused,
  output ctlStrobe_t                 strobe,
  output logic                       reqValid,
  output logic [PRI_COUNT-1:0]       reqEnable
);
  logic [PRI_COUNT-1:0] enterPause;
  logic [PRI_COUNT-1:0] leavePause;
  logic [PRI_COUNT-1:0] groupEvent;
  logic [PRI_COUNT-1:0] priEvent;
  logic [PRI_COUNT-1:0] pend;
  logic [PRI_COUNT-1:0] pendNext;
  logic                 launch;
  logic [PRI_COUNT-1:0] launchMask;

  assign enterPause = ~groupPaused & status.xoffLevel;
  assign leavePause =  groupPaused & status.xonLevel;
  assign groupEvent = enterPause | leavePause;

  always_comb begin
    for (int p = 0; p < PRI_COUNT; p++) priEvent[p] = groupEvent[groupOf(cfgGroup, p)];
  end

  assign launch     = !reqValid && (|pend);
  assign launchMask = launch ? pend : '0;

  // a refresh that lands on the launching edge is already covered
  assign pendNext = (pend & ~launchMask) | priEvent | (status.refreshDue & ~launchMask);

  assign strobe.launch     = launch;
  assign strobe.launchMask = launchMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      groupPaused <= '0;
      pend        <= '0;
      reqValid    <= 1'b0;
      reqEnable   <= '0;
    end else begin
      groupPaused <= (groupPaused | enterPause) & ~leavePause;
      pend        <= pendNext;
      if (launch) begin
        reqValid  <= 1'b1;
        reqEnable <= pend;
      end else if (reqReady) begin
        reqValid  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ppt_pause_gen.sv
module ppt_pause_gen
  import ppt_pkg::*;
#(
  parameter int unsigned OCC_W  = 16,
  parameter int unsigned TIME_W = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        enqValid,
  input  logic [PRI_W-1:0]            enqPri,
  input  logic [OCC_W-1:0]            enqLen,
  input  logic                        deqValid,
  input  logic [PRI_W-1:0]            deqPri,
  input  logic [OCC_W-1:0]            deqLen,
  input  logic [OCC_W-1:0]            cfgCapacity,
  input  logic [OCC_W-1:0]            cfgMaxFrame,
  input  logic [OCC_W-1:0]            cfgLinkDelay,
  input  logic [TIME_W-1:0]           cfgPauseTime,
  input  logic [TIME_W-1:0]           cfgRefresh,
  input  logic [PRI_COUNT*PRI_W-1:0]  cfgGroup,
  output logic                        reqValid,
  input  logic                        reqReady,
  output logic [PRI_COUNT-1:0]        reqEnable,
  output logic [PRI_COUNT*TIME_W-1:0] reqTimes,
  output logic                        errFlag
);
  ctlStrobe_t           strobe;
  dpStatus_t            status;
  logic [PRI_COUNT-1:0] groupPaused;

  ppt_datapath #(.OCC_W(OCC_W), .TIME_W(TIME_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .enqValid    (enqValid),
    .enqPri      (enqPri),
    .enqLen      (enqLen),
    .deqValid    (deqValid),
    .deqPri      (deqPri),
    .deqLen      (deqLen),
    .cfgCapacity (cfgCapacity),
    .cfgMaxFrame (cfgMaxFrame),
    .cfgLinkDelay(cfgLinkDelay),
    .cfgPauseTime(cfgPauseTime),
    .cfgRefresh  (cfgRefresh),
    .cfgGroup    (cfgGroup),
    .groupPaused (groupPaused),
    .strobe      (strobe),
    .status      (status),
    .reqTimes    (reqTimes),
    .errFlag     (errFlag)
  );

  ppt_control u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .status     (status),
    .cfgGroup   (cfgGroup),
    .reqReady   (reqReady),
    .groupPaused(groupPaused),
    .strobe     (strobe),
    .reqValid   (reqValid),
    .reqEnable  (reqEnable)
  );
endmodule

// File: rtl/ppt_pause_gen_checker.sv
module ppt_pause_gen_checker
  import ppt_pkg::*;
#(
  parameter int unsigned TIME_W = 16
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        reqValid,
  input logic                        reqReady,
  input logic [PRI_COUNT-1:0]        reqEnable,
  input logic [PRI_COUNT*TIME_W-1:0] reqTimes,
  input logic                        errFlag
);
  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=> reqValid) else $error("request dropped without acceptance"); // R7

  AST_HOLD_PAYLOAD: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=> ($stable(reqEnable) && $stable(reqTimes)))
    else $error("payload changed while waiting"); // R7

  AST_GAP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqValid) else $error("no idle cycle after accept"); // R7

  AST_ENABLE_NONEMPTY: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (reqEnable != '0)) else $error("empty request"); // R4

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag) else $error("error flag cleared"); // R10

  for (genvar p = 0; p < PRI_COUNT; p++) begin : g_unsel
    AST_UNNAMED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      (reqValid && !reqEnable[p]) |-> (reqTimes[p*TIME_W +: TIME_W] == '0))
      else $error("time set for unnamed priority"); // R4
  end
endmodule

bind ppt_pause_gen ppt_pause_gen_checker #(.TIME_W(TIME_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .reqEnable(reqEnable),
  .reqTimes (reqTimes),
  .errFlag  (errFlag)
);

// File: tb/ppt_pause_gen_bench.sv
`timescale 1ns/1ps
module ppt_pause_gen_bench;
  localparam logic [15:0] PAUSE = 16'h1234;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         enqValid = 1'b0, deqValid = 1'b0;
  logic [2:0]   enqPri = '0, deqPri = '0;
  logic [15:0]  enqLen = '0, deqLen = '0;
  logic [15:0]  cfgCapacity = 16'd4000, cfgMaxFrame = 16'd500, cfgLinkDelay = 16'd200;
  logic [15:0]  cfgPauseTime = PAUSE, cfgRefresh = 16'd60000;
  logic [23:0]  cfgGroup;
  logic         reqValid, reqReady = 1'b1, errFlag;
  logic [7:0]   reqEnable;
  logic [127:0] reqTimes;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;

  typedef struct {
    int           due;
    logic [7:0]   en;
    logic [127:0] times;
    string        tag;
  } expItem_t;
  expItem_t expQ[$];

  ppt_pause_gen u_ppt_pause_gen (
    .clk(clk), .rstN(rstN),
    .enqValid(enqValid), .enqPri(enqPri), .enqLen(enqLen),
    .deqValid(deqValid), .deqPri(deqPri), .deqLen(deqLen),
    .cfgCapacity(cfgCapacity), .cfgMaxFrame(cfgMaxFrame), .cfgLinkDelay(cfgLinkDelay),
    .cfgPauseTime(cfgPauseTime), .cfgRefresh(cfgRefresh), .cfgGroup(cfgGroup),
    .reqValid(reqValid), .reqReady(reqReady), .reqEnable(reqEnable),
    .reqTimes(reqTimes), .errFlag(errFlag)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // expected request: en = named priorities, off = those carrying the pause time
  task automatic pushExp(input int due, input logic [7:0] en, input logic [7:0] off,
                         input string tag);
    expItem_t it;
    it.due = due; it.en = en; it.tag = tag; it.times = '0;
    for (int p = 0; p < 8; p++) if (en[p] && off[p]) it.times[p*16 +: 16] = PAUSE;
    expQ.push_back(it);
  endtask

  // monitor: due cycle on first appearance, payload on acceptance
  bit wasValid = 1'b0;
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (reqValid && !wasValid) begin
        if (expQ.size() == 0)
          check(1'b0, "R2", "unexpected request", {120'd0, reqEnable}, 128'd0);
        else
          check(cyc == expQ[0].due, "R5", {"due cycle of ", expQ[0].tag}, cyc, expQ[0].due);
      end
      if (reqValid && reqReady && expQ.size() != 0) begin
        check(reqEnable == expQ[0].en, expQ[0].tag, "enable vector", reqEnable, expQ[0].en);
        check(reqTimes == expQ[0].times, expQ[0].tag, "pause times", reqTimes, expQ[0].times);
        void'(expQ.pop_front());
      end else if (!reqValid && expQ.size() != 0 && cyc > expQ[0].due) begin
        check(1'b0, expQ[0].tag, "missing request", 128'd0, expQ[0].en);
        void'(expQ.pop_front());
      end
      wasValid = reqValid && !reqReady;
    end
  end

  task automatic drive(input bit isEnq, input int pri, input int len);
    if (isEnq) begin enqValid = 1'b1; enqPri = 3'(pri); enqLen = 16'(len); end
    else       begin deqValid = 1'b1; deqPri = 3'(pri); deqLen = 16'(len); end
    @(negedge clk);
    enqValid = 1'b0; deqValid = 1'b0;
  endtask

  task automatic driveBoth(input int ePri, input int eLen, input int dPri, input int dLen);
    enqValid = 1'b1; enqPri = 3'(ePri); enqLen = 16'(eLen);
    deqValid = 1'b1; deqPri = 3'(dPri); deqLen = 16'(dLen);
    @(negedge clk);
    enqValid = 1'b0; deqValid = 1'b0;
  endtask

  task automatic waitIdle();
    while (expQ.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic quiet(input string req, input string what);
    repeat (6) @(negedge clk);
    check(!reqValid && expQ.size() == 0, req, what, {127'd0, reqValid}, 128'd0);
  endtask

  initial begin
    int n;
    for (int p = 0; p < 8; p++) cfgGroup[p*3 +: 3] = 3'(p);
    repeat (3) @(negedge clk);
    check(!reqValid, "R4", "reqValid in reset", {127'd0, reqValid}, 128'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(!reqValid && !errFlag, "R10", "idle after reset", {126'd0, errFlag, reqValid}, 128'd0);

    // R2 threshold: skid 1200, capacity 4000 -> pause at occupancy 2800
    drive(1'b1, 0, 2799);
    quiet("R2", "no pause at free = skid+1");
    n = cyc; pushExp(n + 3, 8'h01, 8'h01, "R2 pause p0");
    drive(1'b1, 0, 1);
    waitIdle();
    drive(1'b1, 0, 500);
    quiet("R2", "no repeat pause while paused");

    // R3 resume: needs free > 2400, i.e. occupancy below 1600
    drive(1'b0, 0, 1700);
    quiet("R3", "no resume at free = 2*skid");
    n = cyc; pushExp(n + 3, 8'h01, 8'h00, "R3 resume p0");
    drive(1'b0, 0, 1);
    waitIdle();

    // R1 independent priorities
    drive(1'b1, 1, 2000);
    drive(1'b1, 2, 2000);
    quiet("R1", "separate counters below threshold");
    n = cyc; pushExp(n + 3, 8'h04, 8'h04, "R1 pause p2 alone");
    drive(1'b1, 2, 800);
    waitIdle();

    // R6 merge: p1 pauses and p2 resumes in one cycle
    n = cyc; pushExp(n + 3, 8'h06, 8'h02, "R6 merged pause and resume");
    driveBoth(1, 800, 2, 1201);
    waitIdle();
    n = cyc; pushExp(n + 3, 8'h02, 8'h00, "R3 resume p1");
    drive(1'b0, 1, 1201);
    waitIdle();

    // R7 handshake hold and gathering
    reqReady = 1'b0;
    n = cyc; pushExp(n + 3, 8'h08, 8'h08, "R7 held pause p3");
    pushExp(n + 10, 8'h10, 8'h10, "R7 gathered pause p4");
    drive(1'b1, 3, 2800);
    drive(1'b1, 4, 2800);
    while (cyc < n + 6) @(negedge clk);
    check(reqValid && reqEnable == 8'h08, "R7", "request held while not ready",
          {119'd0, reqValid, reqEnable}, {119'd0, 1'b1, 8'h08});
    while (cyc < n + 8) @(negedge clk);
    reqReady = 1'b1;
    waitIdle();
    n = cyc; pushExp(n + 3, 8'h08, 8'h00, "R3 resume p3");
    drive(1'b0, 3, 1201);
    waitIdle();
    n = cyc; pushExp(n + 3, 8'h10, 8'h00, "R3 resume p4");
    drive(1'b0, 4, 1201);
    waitIdle();

    // R8 refresh after cfgRefresh+2 cycles
    cfgRefresh = 16'd20;
    n = cyc; pushExp(n + 3, 8'h20, 8'h20, "R8 first pause p5");
    pushExp(n + 25, 8'h20, 8'h20, "R8 refreshed pause p5");
    drive(1'b1, 5, 2800);
    while (cyc < n + 20) @(negedge clk);
    cfgRefresh = 16'd60000;
    waitIdle();
    n = cyc; pushExp(n + 3, 8'h20, 8'h00, "R3 resume p5");
    drive(1'b0, 5, 1201);
    waitIdle();

    // R9 grouping: p4 and p5 share group 4
    drive(1'b0, 4, 1599);
    drive(1'b0, 5, 1599);
    cfgGroup[5*3 +: 3] = 3'd4;
    drive(1'b1, 4, 1500);
    quiet("R9", "group below threshold");
    n = cyc; pushExp(n + 3, 8'h30, 8'h30, "R9 group pause p4 p5");
    drive(1'b1, 5, 1400);
    waitIdle();
    n = cyc; pushExp(n + 3, 8'h30, 8'h00, "R9 group resume p4 p5");
    drive(1'b0, 4, 1301);
    waitIdle();

    // R10 underflow saturates at zero
    check(!errFlag, "R10", "error flag clear before fault", {127'd0, errFlag}, 128'd0);
    drive(1'b0, 6, 100);
    check(errFlag, "R10", "error flag after underflow", {127'd0, errFlag}, 128'd1);
    drive(1'b1, 6, 2799);
    quiet("R10", "underflowed counter held at zero");
    n = cyc; pushExp(n + 3, 8'h40, 8'h40, "R10 pause p6 after underflow");
    drive(1'b1, 6, 1);
    waitIdle();
    n = cyc; pushExp(n + 3, 8'h40, 8'h00, "R3 resume p6");
    drive(1'b0, 6, 1201);
    waitIdle();

    // R10 overflow saturates at all ones
    n = cyc; pushExp(n + 3, 8'h80, 8'h80, "R10 pause p7");
    drive(1'b1, 7, 65000);
    waitIdle();
    drive(1'b1, 7, 1000);
    quiet("R10", "overflow keeps pause");
    n = cyc; pushExp(n + 3, 8'h80, 8'h00, "R10 resume p7 from saturated count");
    drive(1'b0, 7, 63936);
    waitIdle();
    check(errFlag, "R10", "error flag still set", {127'd0, errFlag}, 128'd1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule